// File: doc/BRIEF.md
# Power Mode Control Register

This block holds the power-control register of a small controller core and turns its contents into three clock-enable outputs: one for the CPU core, one for the peripherals (timers, serial port, interrupt logic) and one for the oscillator. Software writes the register to enter a low-power mode. There are two such modes. In the light-sleep mode only the CPU clock stops. In the deep-sleep mode every clock stops. The register also holds two general-purpose flags and a serial baud-doubling bit, and the baud-doubling bit drives an output directly.

Light sleep ends by itself when the interrupt controller signals that an interrupt has been taken, or when reset is applied. Deep sleep ends only on reset, and taken interrupts have no effect on it. While either sleep mode is active the CPU cannot run, so register writes are ignored and the stored state stays frozen. The clock enables are registered so that they change glitch-free, one cycle after the register contents change.

Register layout (8 bits): bit 7 baud-doubling, bits 6..4 unused, bit 3 flag B, bit 2 flag A, bit 1 deep-sleep request, bit 0 light-sleep request.

Top module: `pwr_ctrl`

## Requirements
- R1: While reset (rst_ni low) is active and after it is released, the read port returns 0x00, baud_dbl_o is low, and cpu_clk_en_o, periph_clk_en_o and osc_en_o are high.
- R2: Bits 3 and 2 are plain storage. A write in run mode stores them, they read back unchanged, and they have no effect on any clock enable.
- R3: Bit 7 is stored on a write in run mode. baud_dbl_o equals the stored bit 7 at all times.
- R4: Bits 6..4 always read as 0, whatever value is written to them.
- R5: A run-mode write with bit 0 set and bit 1 clear stores the light-sleep bit. One cycle after the register changes, cpu_clk_en_o goes low, while periph_clk_en_o and osc_en_o stay high.
- R6: An irq_taken_i pulse during light sleep clears bit 0. One cycle later cpu_clk_en_o is high again, and the other bits keep their values.
- R7: Writes are ignored while bit 0 or bit 1 is set, and the read-back value is unchanged after such a write.
- R8: A run-mode write with bit 1 set stores the deep-sleep bit. One cycle after the register changes, all three clock enables are low.
- R9: irq_taken_i has no effect in deep sleep. The register and all enables stay unchanged.
- R10: When bits 1 and 0 are both set, deep sleep takes precedence and all three enables are low.
- R11: An active-low reset from deep sleep clears the register and sets all enables high.
- R12: irq_taken_i in run mode has no effect on the register or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W (8) | Register write data |
| rd_data_o | output | REG_W (8) | Register read data |
| irq_taken_i | input | 1 | Pulse: an enabled interrupt has been taken |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| baud_dbl_o | output | 1 | Serial baud-doubling flag |

## Verification
The bench builds the block with its default parameters: an 8-bit register with two general-purpose flags at bits 3..2. With these values every field is reachable through the one write/read port. This covers the unused-bit masking, both sleep entries, precedence when both sleep bits are written together, and the frozen state seen after writes and interrupts arrive while asleep. Exit paths are exercised both by a taken interrupt and by reset from each sleep mode.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_LIGHT = 2'd1,
    PM_DEEP  = 2'd2
  } pm_mode_e;

  typedef enum int unsigned {
    DOM_CPU    = 0,
    DOM_PERIPH = 1,
    DOM_OSC    = 2
  } clk_dom_e;

  localparam int unsigned NUM_DOM = 3;

  // Which clock domain survives in which mode.
  function automatic logic dom_on(input int unsigned dom, input pm_mode_e mode);
    unique case (mode)
      PM_RUN:   dom_on = 1'b1;
      PM_LIGHT: dom_on = (dom != DOM_CPU);
      default:  dom_on = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pwr_ctrl_mode.sv
module pwr_ctrl_mode
  import pwr_ctrl_pkg::*;
(
  input  logic     light_q_i,
  input  logic     deep_q_i,
  input  logic     wr_en_i,
  input  logic     irq_taken_i,
  output pm_mode_e mode_o,
  output logic     wr_accept_o,
  output logic     wake_o
);
  always_comb begin
    if (deep_q_i)       mode_o = PM_DEEP;  // deep wins over light
    else if (light_q_i) mode_o = PM_LIGHT;
    else                mode_o = PM_RUN;
  end

  assign wr_accept_o = wr_en_i && (mode_o == PM_RUN);
  assign wake_o      = irq_taken_i && (mode_o == PM_LIGHT);
endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned GP_W     = 2,
  parameter int unsigned GP_LSB   = 2,
  parameter int unsigned LIGHT_BIT = 0,
  parameter int unsigned DEEP_BIT  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_accept_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             wake_i,
  output logic             light_q_o,
  output logic             deep_q_o,
  output logic [GP_W-1:0]  gp_q_o,
  output logic             baud_q_o
);
  localparam int unsigned BAUD_BIT = REG_W - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      light_q_o <= 1'b0;
      deep_q_o  <= 1'b0;
      baud_q_o  <= 1'b0;
    end else if (wr_accept_i) begin
      light_q_o <= wr_data_i[LIGHT_BIT];
      deep_q_o  <= wr_data_i[DEEP_BIT];
      baud_q_o  <= wr_data_i[BAUD_BIT];
    end else if (wake_i) begin
      light_q_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < GP_W; g++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          gp_q_o[g] <= 1'b0;
      else if (wr_accept_i) gp_q_o[g] <= wr_data_i[GP_LSB+g];
    end
  end
endmodule

// File: rtl/pwr_ctrl_clk_en.sv
module pwr_ctrl_clk_en
  import pwr_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pm_mode_e           mode_i,
  output logic [NUM_DOM-1:0] en_o
);
  // Registered so the enables never glitch.
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_o[d] <= 1'b1;
      else         en_o[d] <= dom_on(d, mode_i);
    end
  end
endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned GP_W   = 2,
  parameter int unsigned GP_LSB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             irq_taken_i,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             osc_en_o,
  output logic             baud_dbl_o
);
  localparam int unsigned LIGHT_BIT = 0;
  localparam int unsigned DEEP_BIT  = 1;
  localparam int unsigned BAUD_BIT  = REG_W - 1;

  logic               light_q, deep_q, baud_q;
  logic [GP_W-1:0]    gp_q;
  logic               wr_accept, wake;
  pm_mode_e           mode;
  logic [NUM_DOM-1:0] en;

  pwr_ctrl_mode u_mode (
    .light_q_i   (light_q),
    .deep_q_i    (deep_q),
    .wr_en_i     (wr_en_i),
    .irq_taken_i (irq_taken_i),
    .mode_o      (mode),
    .wr_accept_o (wr_accept),
    .wake_o      (wake)
  );

  pwr_ctrl_regs #(
    .REG_W(REG_W), .GP_W(GP_W), .GP_LSB(GP_LSB),
    .LIGHT_BIT(LIGHT_BIT), .DEEP_BIT(DEEP_BIT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_accept_i (wr_accept),
    .wr_data_i   (wr_data_i),
    .wake_i      (wake),
    .light_q_o   (light_q),
    .deep_q_o    (deep_q),
    .gp_q_o      (gp_q),
    .baud_q_o    (baud_q)
  );

  pwr_ctrl_clk_en u_clk_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .en_o   (en)
  );

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[LIGHT_BIT]            = light_q;
    rd_data_o[DEEP_BIT]             = deep_q;
    rd_data_o[GP_LSB +: GP_W]       = gp_q;
    rd_data_o[BAUD_BIT]             = baud_q;
  end

  assign cpu_clk_en_o    = en[DOM_CPU];
  assign periph_clk_en_o = en[DOM_PERIPH];
  assign osc_en_o        = en[DOM_OSC];
  assign baud_dbl_o      = baud_q;
endmodule

// File: rtl/pwr_ctrl_chk.sv
module pwr_ctrl_chk #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned GP_W   = 2,
  parameter int unsigned GP_LSB = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_taken_i,
  input logic             cpu_clk_en_o,
  input logic             periph_clk_en_o,
  input logic             osc_en_o,
  input logic             baud_dbl_o
);
  localparam int unsigned USED_HI = GP_LSB + GP_W;
  localparam int unsigned BAUD_BIT = REG_W - 1;
  logic light, deep;
  assign light = rd_data_o[0];
  assign deep  = rd_data_o[1];

  a_r3_baud_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_dbl_o == rd_data_o[BAUD_BIT]);

  a_r4_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BAUD_BIT-1:USED_HI] == '0);

  a_r5_light_stops_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (light && !deep) |=> (!cpu_clk_en_o && periph_clk_en_o && osc_en_o));

  a_r6_wake_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (light && !deep && irq_taken_i) |=> !rd_data_o[0]);

  a_r7_light_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (light && !irq_taken_i) |=> $stable(rd_data_o));

  a_r8_deep_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep |=> (!cpu_clk_en_o && !periph_clk_en_o && !osc_en_o));

  a_r9_deep_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep |=> $stable(rd_data_o));

  a_r12_run_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!light && !deep) |=> (cpu_clk_en_o && periph_clk_en_o && osc_en_o));

  a_r2_run_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!light && !deep && wr_en_i) |=> 1'b1 && (rd_data_o[BAUD_BIT-1:USED_HI] == '0));
endmodule

bind pwr_ctrl pwr_ctrl_chk #(.REG_W(REG_W), .GP_W(GP_W), .GP_LSB(GP_LSB)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .rd_data_o       (rd_data_o),
  .irq_taken_i     (irq_taken_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .osc_en_o        (osc_en_o),
  .baud_dbl_o      (baud_dbl_o)
);

// File: tb/pwr_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_ctrl_tb;
  localparam int unsigned REG_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [REG_W-1:0] wr_data_i = '0;
  logic             irq_taken_i = 1'b0;
  logic [REG_W-1:0] rd_data_o;
  logic             cpu_clk_en_o, periph_clk_en_o, osc_en_o, baud_dbl_o;

  always #2 clk_i = ~clk_i;

  pwr_ctrl u_dut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .rd_data_o       (rd_data_o),
    .irq_taken_i     (irq_taken_i),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .osc_en_o        (osc_en_o),
    .baud_dbl_o      (baud_dbl_o)
  );

  typedef struct {
    logic [REG_W-1:0] rd;
    logic             cpu, per, osc, baud;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic push(input logic [REG_W-1:0] rd, input logic c, input logic p,
                      input logic o, input logic b, input string tag);
    exp_t e;
    e.rd = rd; e.cpu = c; e.per = p; e.osc = o; e.baud = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // One bus operation, then one more edge so the registered enables settle.
  task automatic op(input logic wr, input logic [REG_W-1:0] d, input logic irq);
    @(posedge clk_i); #1;
    wr_en_i = wr; wr_data_i = d; irq_taken_i = irq;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wr_data_i = '0; irq_taken_i = 1'b0;
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  // Monitor: compare one queued expectation per falling edge.
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (rd_data_o !== e.rd || cpu_clk_en_o !== e.cpu || periph_clk_en_o !== e.per ||
          osc_en_o !== e.osc || baud_dbl_o !== e.baud) begin
        errors++;
        $display("FAIL %s: got rd=%h cpu=%b per=%b osc=%b baud=%b exp rd=%h cpu=%b per=%b osc=%b baud=%b",
                 e.tag, rd_data_o, cpu_clk_en_o, periph_clk_en_o, osc_en_o, baud_dbl_o,
                 e.rd, e.cpu, e.per, e.osc, e.baud);
      end
    end
  end

  initial begin
    // R1: during reset
    repeat (2) @(posedge clk_i);
    #1 push(8'h00, 1, 1, 1, 0, "R1 in reset");
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(posedge clk_i); #1 push(8'h00, 1, 1, 1, 0, "R1 after release");

    op(1, 8'hFC, 0); push(8'h8C, 1, 1, 1, 1, "R2 R3 R4 flags baud unused");
    op(1, 8'h08, 0); push(8'h08, 1, 1, 1, 0, "R2 R3 flag only");
    op(1, 8'h04, 0); push(8'h04, 1, 1, 1, 0, "R2 flag A only");
    op(0, 8'h00, 1); push(8'h04, 1, 1, 1, 0, "R12 irq in run");
    op(1, 8'h8D, 0); push(8'h8D, 0, 1, 1, 1, "R5 enter light");
    op(1, 8'h00, 0); push(8'h8D, 0, 1, 1, 1, "R7 write in light");
    op(0, 8'h00, 1); push(8'h8C, 1, 1, 1, 1, "R6 wake from light");
    op(1, 8'h86, 0); push(8'h86, 0, 0, 0, 1, "R8 enter deep");
    op(0, 8'h00, 1); push(8'h86, 0, 0, 0, 1, "R9 irq in deep");
    op(1, 8'h00, 0); push(8'h86, 0, 0, 0, 1, "R7 write in deep");
    do_reset();      push(8'h00, 1, 1, 1, 0, "R11 reset from deep");
    op(1, 8'h03, 0); push(8'h03, 0, 0, 0, 0, "R10 both sleep bits");
    op(0, 8'h00, 1); push(8'h03, 0, 0, 0, 0, "R10 R9 irq with both");
    do_reset();      push(8'h00, 1, 1, 1, 0, "R11 reset again");
    op(1, 8'h01, 0); push(8'h01, 0, 1, 1, 0, "R5 light plain");
    do_reset();      push(8'h00, 1, 1, 1, 0, "R1 reset from light");

    wait (exp_q.size() == 0);
    @(posedge clk_i);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule